// File: doc/BRIEF.md
# Calibrated Read-Enable Delay Aligner

The memory returns read data with no strobe that marks it valid. This block creates the write-enable for the read-capture FIFO of one data byte. It takes the controller's read-enable pulse and passes it through a delay line of up to `DEPTH` stages, clocked at the half-rate fabric clock. A tap register picks one stage, and one more flip-flop registers that stage before it drives the FIFO enable. A burst of length 4 gives a one-cycle pulse and a burst of length 8 gives a two-cycle pulse. The delay line keeps the pulse width. The system places one instance next to each data byte.

The tap is learned and not fixed. When the calibration input is high, the first read-enable pulse starts a cycle timer. The capture path raises a pattern-match input when the expected training data appears. The tap is then set so that the aligned enable lines up with that match cycle. If no match arrives within the window, the block keeps the largest tap and raises an error flag. Outside calibration the tap is frozen. The tap stays visible as an output.

Top module: `rden_aligner`

## Requirements
- R1: After a synchronous reset, `rden_out` is 0, `tap_sel` is 0 and `cal_err` is 0.
- R2: A read-enable level applied in cycle c appears on `rden_out` in cycle c + `tap_sel` + 2. One-cycle and two-cycle pulses keep their width.
- R3: While `cal_mode` is low, `tap_sel` does not change, whatever `rden_in` and `pat_match` do.
- R4: In a calibration session, let the first `rden_in` high be sampled at edge E0 and the first `pat_match` high afterwards be sampled at edge Em, with 2 <= m <= 17. After Em, `tap_sel` equals m - 2.
- R5: A match sampled at E1 (m = 1) gives `tap_sel` = 0.
- R6: If no match is sampled at E1 through E17, then after E17 `tap_sel` = DEPTH-1 (15) and `cal_err` = 1. A match exactly at E17 gives 15 with `cal_err` = 0.
- R7: After a tap is latched, further `rden_in` and `pat_match` activity in the same session has no effect. A new session needs `cal_mode` to go low and then high again.
- R8: `cal_err` keeps its value until the next session starts timing, and is cleared at that start edge (E0).
- R9: If `cal_mode` goes low before a match or a timeout, the measurement is abandoned and `tap_sel` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate fabric clock (90-degree phase) |
| rst | input | 1 | Synchronous active-high reset |
| rden_in | input | 1 | Read-enable pulse from the controller |
| cal_mode | input | 1 | High while delay calibration runs |
| pat_match | input | 1 | Capture path has seen the training pattern |
| tap_sel | output | $clog2(DEPTH) | Selected delay tap |
| cal_err | output | 1 | No match was seen within the window |
| rden_out | output | 1 | Aligned FIFO write-enable |

## Verification
The hardest case to reach is the edge of the measurement window: a match on the very last counted edge against no match at all. Both give the largest tap, and only the error flag tells them apart. The stimulus places the match by counting edges from the start pulse, so m = 1, 17 and "never" are all hit exactly. It then follows each calibration with a timed pulse in normal mode to confirm the learned latency. Abandoned sessions and activity after a latched tap are driven too. A behavioural model tracks every cycle.

// File: rtl/rden_align_pkg.sv
`timescale 1ns/100ps
package rden_align_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_RUN  = 2'd1,
    CAL_DONE = 2'd2
  } cal_state_e;
endpackage

// File: rtl/rden_delay_line.sv
`timescale 1ns/100ps
// Tapped shift register followed by a registered output stage.
module rden_delay_line #(
  parameter int DEPTH = 16,
  parameter int TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [TAP_W-1:0] tap,
  output logic             dout
);
  logic [DEPTH-1:0] stages;
  logic             tapped;

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= {stages[DEPTH-2:0], din};
  end

  // stage i holds the input sampled i+1 edges ago
  always_comb begin
    tapped = stages[DEPTH-1];
    for (int i = 0; i < DEPTH; i++) begin
      if (tap == TAP_W'(i)) tapped = stages[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= tapped;
  end
endmodule

// File: rtl/rden_cal_ctrl.sv
`timescale 1ns/100ps
// Times the gap from read-enable to pattern match and latches the tap.
module rden_cal_ctrl
  import rden_align_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_mode,
  input  logic             rden_in,
  input  logic             pat_match,
  output logic [TAP_W-1:0] tap,
  output logic             err
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int LIMIT   = DEPTH;
  localparam int MAX_TAP = DEPTH - 1;

  cal_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CAL_IDLE;
      cnt   <= '0;
      tap   <= '0;
      err   <= 1'b0;
    end else if (!cal_mode) begin
      state <= CAL_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        CAL_IDLE: begin
          if (rden_in) begin
            state <= CAL_RUN;
            cnt   <= '0;
            err   <= 1'b0;
          end
        end
        CAL_RUN: begin
          if (pat_match) begin
            tap   <= (cnt == '0) ? '0 : TAP_W'(cnt - 1'b1);
            state <= CAL_DONE;
          end else if (cnt == CNT_W'(LIMIT)) begin
            tap   <= TAP_W'(MAX_TAP);
            err   <= 1'b1;
            state <= CAL_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= CAL_DONE;
      endcase
    end
  end
endmodule

// File: rtl/rden_aligner.sv
`timescale 1ns/100ps
module rden_aligner #(
  parameter int DEPTH = 16,
  parameter int TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rden_in,
  input  logic             cal_mode,
  input  logic             pat_match,
  output logic [TAP_W-1:0] tap_sel,
  output logic             cal_err,
  output logic             rden_out
);
  rden_cal_ctrl #(.DEPTH(DEPTH), .TAP_W(TAP_W)) cal_i (
    .clk       (clk),
    .rst       (rst),
    .cal_mode  (cal_mode),
    .rden_in   (rden_in),
    .pat_match (pat_match),
    .tap       (tap_sel),
    .err       (cal_err)
  );

  rden_delay_line #(.DEPTH(DEPTH), .TAP_W(TAP_W)) dly_i (
    .clk  (clk),
    .rst  (rst),
    .din  (rden_in),
    .tap  (tap_sel),
    .dout (rden_out)
  );
endmodule

// File: rtl/rden_aligner_chk.sv
`timescale 1ns/100ps
module rden_aligner_chk #(
  parameter int DEPTH = 16,
  parameter int TAP_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             rden_in,
  input logic             cal_mode,
  input logic             pat_match,
  input logic [TAP_W-1:0] tap_sel,
  input logic             cal_err,
  input logic             rden_out
);
  localparam logic [TAP_W-1:0] MAX_TAP = TAP_W'(DEPTH - 1);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst_q |-> (!rden_out && tap_sel == '0 && !cal_err));

  // R3
  a_r3_tap_frozen: assert property (@(posedge clk) disable iff (rst)
    !cal_mode |=> $stable(tap_sel));

  // R4
  a_r4_tap_cause: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && !$stable(tap_sel)) |-> ($past(cal_mode) && ($past(pat_match) || cal_err)));

  // R6
  a_r6_err_max_tap: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_err) |-> (tap_sel == MAX_TAP));

  // R7
  a_r7_err_in_session: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_err) |-> $past(cal_mode));

  // R8
  a_r8_err_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && $fell(cal_err)) |-> ($past(cal_mode) && $past(rden_in)));
endmodule

bind rden_aligner rden_aligner_chk #(.DEPTH(DEPTH), .TAP_W(TAP_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rden_in   (rden_in),
  .cal_mode  (cal_mode),
  .pat_match (pat_match),
  .tap_sel   (tap_sel),
  .cal_err   (cal_err),
  .rden_out  (rden_out)
);

// File: tb/rden_aligner_tb_top.sv
`timescale 1ns/100ps
module rden_aligner_tb_top;
  localparam int DEPTH = 16;
  localparam int TAP_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rden_in = 1'b0;
  logic cal_mode = 1'b0;
  logic pat_match = 1'b0;
  logic [TAP_W-1:0] tap_sel;
  logic cal_err;
  logic rden_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rden_aligner #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .rden_in(rden_in), .cal_mode(cal_mode),
    .pat_match(pat_match), .tap_sel(tap_sel), .cal_err(cal_err),
    .rden_out(rden_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int hist[$];
  int m_tap = 0, m_err = 0, m_phase = 0, m_elapsed = 0, m_out = 0;

  always @(posedge clk) begin
    if (rst) begin
      hist = {};
      for (int i = 0; i < 24; i++) hist.push_back(0);
      m_tap = 0; m_err = 0; m_phase = 0; m_elapsed = 0; m_out = 0;
    end else begin
      hist.push_front(int'(rden_in));
      void'(hist.pop_back());
      m_out = hist[m_tap + 1];
      if (!cal_mode) m_phase = 0;
      else if (m_phase == 0) begin
        if (rden_in) begin m_phase = 1; m_elapsed = 0; m_err = 0; end
      end else if (m_phase == 1) begin
        m_elapsed++;
        if (pat_match) begin
          m_tap = (m_elapsed < 2) ? 0 : m_elapsed - 2;
          m_phase = 2;
        end else if (m_elapsed == DEPTH + 1) begin
          m_tap = DEPTH - 1; m_err = 1; m_phase = 2;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(int'(rden_out) == m_out, "R2 aligned enable", int'(rden_out), m_out);
      check(int'(tap_sel) == m_tap, "R4 tap", int'(tap_sel), m_tap);
      check(int'(cal_err) == m_err, "R6 error flag", int'(cal_err), m_err);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // m = 0 means no match is ever given
  task automatic calibrate(input int m);
    cal_mode = 1'b0; step(1);
    cal_mode = 1'b1; step(1);
    rden_in = 1'b1; step(1);
    rden_in = 1'b0;
    if (m == 0) step(DEPTH + 4);
    else begin
      if (m > 1) step(m - 1);
      pat_match = 1'b1; step(1);
      pat_match = 1'b0;
    end
  endtask

  task automatic latency(input int width, input int exp, input string req);
    int n = 0;
    cal_mode = 1'b0; step(1);
    rden_in = 1'b1; step(width);
    rden_in = 1'b0;
    n = width;
    while (!rden_out && n < 40) begin step(1); n++; end
    check(n == exp, req, n, exp);
    n = 0;
    while (rden_out && n < 40) begin step(1); n++; end
    check(n == width, {req, " width"}, n, width);
    step(DEPTH + 4);
  endtask

  initial begin
    step(3);
    check(rden_out == 1'b0 && tap_sel == '0 && cal_err == 1'b0, "R1 reset state",
          int'(tap_sel) + int'(rden_out) + int'(cal_err), 0);
    rst = 1'b0; step(2);

    latency(1, 2, "R2 latency tap0 BL4");
    latency(2, 2, "R2 latency tap0 BL8");

    // R3: activity with calibration off
    rden_in = 1'b1; pat_match = 1'b1; step(3);
    rden_in = 1'b0; pat_match = 1'b0; step(2);
    check(tap_sel == '0, "R3 tap frozen", int'(tap_sel), 0);

    calibrate(5);
    check(tap_sel == 4'd3, "R4 m=5", int'(tap_sel), 3);
    latency(1, 5, "R2 latency tap3");

    calibrate(1);
    check(tap_sel == 4'd0, "R5 m=1", int'(tap_sel), 0);

    calibrate(6);
    // R7: second try in same session
    rden_in = 1'b1; step(1); rden_in = 1'b0; step(8);
    pat_match = 1'b1; step(1); pat_match = 1'b0; step(2);
    check(tap_sel == 4'd4, "R7 session locked", int'(tap_sel), 4);

    calibrate(0);
    check(tap_sel == 4'd15 && cal_err, "R6 timeout", int'(tap_sel) + 100*int'(cal_err), 115);
    step(3);
    check(cal_err == 1'b1, "R8 error held", int'(cal_err), 1);
    latency(2, 17, "R2 latency tap15");

    calibrate(3);
    check(cal_err == 1'b0 && tap_sel == 4'd1, "R8 error cleared",
          int'(tap_sel) + 100*int'(cal_err), 1);

    calibrate(17);
    check(tap_sel == 4'd15 && !cal_err, "R6 match at window end",
          int'(tap_sel) + 100*int'(cal_err), 15);

    calibrate(8);
    // R9: abandon a session
    cal_mode = 1'b0; step(1);
    cal_mode = 1'b1; step(1);
    rden_in = 1'b1; step(1); rden_in = 1'b0; step(3);
    cal_mode = 1'b0; step(1);
    pat_match = 1'b1; step(1); pat_match = 1'b0; step(2);
    check(tap_sel == 4'd6, "R9 abandoned", int'(tap_sel), 6);

    step(5);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule